// File: doc/BRIEF.md
# Dual-Source Video Capture Multiplexer

This block sits between two camera sources and a processor's parallel data port. One source is a 10-bit converter sampling an analog video signal, whose sync pulses arrive from an external separator; the other is a native 14-bit digital camera stream that is already single-ended. Both sources run at one pixel rate. The block derives that rate by dividing a faster reference clock by four (48 MHz in, 12 MHz out) and registers one pixel per sample period from whichever source is selected.

A host sets the run flag and the source select by writing a 4-bit word on a local bus; the write counts only when two upper address bits match a decode value. Both settings take effect together at the next frame-sync edge, so a frame is never cut short or mixed between sources. Frame-start and line-start interrupt pulses tell the processor where it is in the 320 by 240 frame. The output bus floats whenever the processor selects its boot memory, which shares the same data lines.

Top module: `vidcap_mux`

## Requirements
- R1: `samp_clk` has a period of DIV (default 4) reference cycles, high for the second half; pixels, sync inputs and all outputs other than `pix_bus` enable change once per period, just after `samp_clk` falls.
- R2: In analog mode (mode bit 0) the bus carries converter bits [9:2] in bus bits [7:0], with bus bits [13:8] zero.
- R3: In digital mode (mode bit 1) the bus carries all 14 digital pixel bits unchanged.
- R4: The written run and mode bits take effect only at a sample where `fsync_in` is high after being low at the previous sample; both are adopted at that same sample.
- R5: After a stop is written, pixels keep being delivered until the next frame-sync edge, and none after it.
- R6: `irq_frame` is high for one sample period after a frame-sync edge at which run is adopted as 1; `irq_line` is high for one sample period after a sample where `lsync_in` rises while capture is running.
- R7: `pix_valid` is high for one sample period for each captured pixel; no pixel is captured while capture is stopped or while either sync input is high, and the bus then keeps its last value.
- R8: While `boot_cs_n` is low, `pix_bus` is high-impedance; it drives the held pixel again as soon as `boot_cs_n` returns high.
- R9: A control write happens on a reference cycle with `host_wr` high and `host_addr` equal to 2'b10; data bit 0 is run, bit 1 is mode, bits 3:2 are ignored, and a write at any other address has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock (DIV times the pixel rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| ana_pix | input | 10 | Analog converter sample |
| dig_pix | input | 14 | Digital camera pixel |
| fsync_in | input | 1 | Frame sync, high during frame blanking |
| lsync_in | input | 1 | Line sync, high during line blanking |
| host_addr | input | 2 | Upper local-bus address bits |
| host_data | input | 4 | Local-bus control word |
| host_wr | input | 1 | Local-bus write strobe |
| boot_cs_n | input | 1 | Boot-memory chip select, active low |
| samp_clk | output | 1 | Pixel sampling clock to the sources |
| pix_bus | output | 14 | Pixel bus to the processor, tri-stated |
| pix_valid | output | 1 | One sample period per captured pixel |
| irq_frame | output | 1 | Frame-start interrupt pulse |
| irq_line | output | 1 | Line-start interrupt pulse |

## Verification
The bench writes a source change and a stop in the middle of a frame and checks that the old source and the running state persist until the next frame-sync edge; a design that applied them at once would switch bus width or drop pixels mid-frame. It feeds analog samples with nonzero low bits and all-ones values to catch a converter slice taken from the wrong bits or not zero-extended, and a write at a wrong address to catch a missing address decode. It also pulls `boot_cs_n` low mid-stream, where a design that kept driving would read back pixel data instead of the pulled-up floating bus.

// File: rtl/vidcap_mux.sv
module vidcap_mux #(
  parameter int        DIV       = 4,
  parameter int        ADC_W     = 10,
  parameter int        KEEP_W    = 8,
  parameter int        PIX_W     = 14,
  parameter logic [1:0] CTRL_ADDR = 2'b10
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [ADC_W-1:0] ana_pix,
  input  logic [PIX_W-1:0] dig_pix,
  input  logic             fsync_in,
  input  logic             lsync_in,
  input  logic [1:0]       host_addr,
  input  logic [3:0]       host_data,
  input  logic             host_wr,
  input  logic             boot_cs_n,
  output logic             samp_clk,
  output logic [PIX_W-1:0] pix_bus,
  output logic             pix_valid,
  output logic             irq_frame,
  output logic             irq_line
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  logic [CW-1:0]    cnt;
  logic             samp_en;
  logic             run_req, mode_req, run_act, mode_act;
  logic             fs_q, ls_q;
  logic             fs_rise, ls_rise, run_nxt, mode_nxt, take;
  logic [PIX_W-1:0] data_q, ana_ext;

  assign samp_en  = (cnt == LAST);
  assign samp_clk = (cnt >= HALF);
  assign fs_rise  = fsync_in & ~fs_q;
  assign ls_rise  = lsync_in & ~ls_q;
  assign run_nxt  = fs_rise ? run_req  : run_act;
  assign mode_nxt = fs_rise ? mode_req : mode_act;
  assign take     = run_nxt & ~fsync_in & ~lsync_in;
  assign ana_ext  = PIX_W'(ana_pix[ADC_W-1 -: KEEP_W]);
  assign pix_bus  = boot_cs_n ? data_q : {PIX_W{1'bz}};

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= samp_en ? '0 : cnt + 1'b1;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      run_req  <= 1'b0;
      mode_req <= 1'b0;
    end else if (host_wr && host_addr == CTRL_ADDR) begin
      run_req  <= host_data[0];
      mode_req <= host_data[1];
    end

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      run_act   <= 1'b0;
      mode_act  <= 1'b0;
      fs_q      <= 1'b0;
      ls_q      <= 1'b0;
      irq_frame <= 1'b0;
      irq_line  <= 1'b0;
      pix_valid <= 1'b0;
      data_q    <= '0;
    end else if (samp_en) begin
      run_act   <= run_nxt;
      mode_act  <= mode_nxt;
      fs_q      <= fsync_in;
      ls_q      <= lsync_in;
      irq_frame <= fs_rise & run_req;
      irq_line  <= ls_rise & run_nxt;
      pix_valid <= take;
      if (take) data_q <= mode_nxt ? dig_pix : ana_ext;
    end

  assert_samp_gap_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    samp_en |=> !samp_en);
  assert_valid_phase_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$past(samp_en) |-> $stable(pix_valid));
  assert_valid_running_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pix_valid |-> run_act);
  assert_mode_hold_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !(samp_en && fsync_in && !fs_q) |=> $stable(mode_act) && $stable(run_act));
  assert_ana_zero_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (pix_valid && !mode_act) |-> (data_q[PIX_W-1:KEEP_W] == '0));
  assert_irq_run_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    irq_frame |-> run_act);
endmodule

// File: tb/vidcap_mux_tb.sv
`timescale 1ns/1ps
module vidcap_mux_tb;
  logic        clk_ref = 1'b0, rst_n = 1'b0;
  logic [9:0]  ana_pix = '0;
  logic [13:0] dig_pix = '0;
  logic        fsync_in = 1'b0, lsync_in = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [3:0]  host_data = '0;
  logic        host_wr = 1'b0, boot_cs_n = 1'b1;
  logic        samp_clk, pix_valid, irq_frame, irq_line;
  tri1  [13:0] pix_bus;
  int checks = 0, fails = 0;

  always #2.5 clk_ref = ~clk_ref;

  vidcap_mux u_dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .ana_pix(ana_pix), .dig_pix(dig_pix),
    .fsync_in(fsync_in), .lsync_in(lsync_in), .host_addr(host_addr),
    .host_data(host_data), .host_wr(host_wr), .boot_cs_n(boot_cs_n),
    .samp_clk(samp_clk), .pix_bus(pix_bus), .pix_valid(pix_valid),
    .irq_frame(irq_frame), .irq_line(irq_line));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge samp_clk); #1;
  endtask

  task automatic host_write(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk_ref);
    host_addr = a; host_data = d; host_wr = 1'b1;
    @(negedge clk_ref);
    host_wr = 1'b0;
  endtask

  task automatic frame_edge();
    fsync_in = 1'b1; tick(); fsync_in = 1'b0;
  endtask

  task automatic t_reset();
    chk("R7 reset valid", pix_valid, 0);
    chk("R6 reset irq", {irq_frame, irq_line}, 0);
    chk("R8 reset bus", pix_bus, 0);
  endtask

  task automatic t_divider();
    int hi = 0, per = 0;
    @(posedge samp_clk);
    while (samp_clk === 1'b1) begin @(posedge clk_ref); #0.1; hi++; end
    while (samp_clk === 1'b0) begin @(posedge clk_ref); #0.1; per++; end
    chk("R1 high cycles", hi, 2);
    chk("R1 period", hi + per, 4);
  endtask

  task automatic t_analog();
    host_write(2'b10, 4'b1101);
    tick();
    chk("R4 no start before frame edge", pix_valid, 0);
    frame_edge();
    chk("R6 irq_frame", irq_frame, 1);
    chk("R7 no pixel during sync", pix_valid, 0);
    ana_pix = 10'h3FD; tick();
    chk("R2 analog all ones", pix_bus, 14'h00FF);
    chk("R7 valid", pix_valid, 1);
    chk("R6 irq_frame one period", irq_frame, 0);
    lsync_in = 1'b1; tick(); lsync_in = 1'b0;
    chk("R6 irq_line", irq_line, 1);
    chk("R7 held bus during line sync", pix_bus, 14'h00FF);
    ana_pix = 10'h156; tick();
    chk("R2 analog slice", pix_bus, 14'h0055);
    chk("R6 irq_line one period", irq_line, 0);
  endtask

  task automatic t_mode_switch();
    host_write(2'b10, 4'b0011);
    dig_pix = 14'h2ABC; ana_pix = 10'h0F0; tick();
    chk("R4 mode held mid-frame", pix_bus, 14'h003C);
    frame_edge();
    tick();
    chk("R3 digital pixel", pix_bus, 14'h2ABC);
    dig_pix = 14'h1543; tick();
    chk("R3 digital pixel 2", pix_bus, 14'h1543);
  endtask

  task automatic t_bad_addr();
    host_write(2'b01, 4'b0000);
    host_write(2'b11, 4'b0000);
    frame_edge(); tick();
    chk("R9 wrong address ignored", pix_valid, 1);
  endtask

  task automatic t_boot_cs();
    boot_cs_n = 1'b0; #3;
    chk("R8 floating", pix_bus, 14'h3FFF);
    boot_cs_n = 1'b1; #3;
    chk("R8 drives again", pix_bus, 14'h1543);
  endtask

  task automatic t_stop();
    host_write(2'b10, 4'b0010);
    dig_pix = 14'h0777; tick();
    chk("R5 still capturing", pix_valid, 1);
    chk("R5 pixel after stop write", pix_bus, 14'h0777);
    frame_edge();
    chk("R6 no irq when stopping", irq_frame, 0);
    dig_pix = 14'h0101; tick();
    chk("R5 stopped valid", pix_valid, 0);
    chk("R7 bus held when stopped", pix_bus, 14'h0777);
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_ref);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_divider();
    tick();
    t_analog();
    t_mode_switch();
    t_bad_addr();
    t_boot_cs();
    t_stop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule